// File: doc/BRIEF.md
# Hardware Trigger and Burst Qualifier

This per-channel block sits between a raw hardware trigger line and a transfer engine and decides when items may move. The raw line is first brought into the local clock domain. Four configuration inputs then shape it: an enable, a choice between edge and level sensitivity, a polarity, and a burst mode with a power-of-two burst size. The result is an item request that the engine accepts one item at a time.

An edge starts one complete burst. A level that stays active keeps starting bursts back to back, and it is re-examined only when a burst ends. An edge that arrives during a burst is held as a single pending trigger and served as soon as the burst finishes. A software clear input drops any pending trigger and cuts the running burst short after the item now being requested. On the last item of a burst, two wrap outputs tell the address generators to return the source address, the destination address or both to the value they had at the start of the burst.

Top module: `trig_burst_qual`

## Requirements
- R1: After reset, itemReq, burstLast, srcWrapOut and dstWrapOut are all low, and no trigger is pending.
- R2: While cfgTrigEn is 0, changes on trigIn produce no item request.
- R3: cfgTrigPol=1 makes a rising edge (edge mode) or a high level (level mode) the active condition. cfgTrigPol=0 makes it a falling edge or a low level. In edge mode with cfgTrigPol=1, the falling edge of a pulse starts nothing.
- R4: trigIn passes through two synchronizer flops. If a change on trigIn is captured at rising clock edge k, itemReq is high after edge k+2.
- R5: With cfgBurstEn=0, each active trigger grants exactly one item. A grant is a cycle in which itemReq and itemAck are both high.
- R6: With cfgBurstEn=1, an edge trigger grants 2^P items, where P is cfgBurstPow. Values of P above 10 are treated as 10, which gives at most 1024 items.
- R7: In level mode (cfgTrigLevel=1), bursts start one after another while the level stays active. The level is checked at each burst boundary. Once the level is inactive and the current burst has ended, no further item is granted.
- R8: Active edges that arrive while a burst is running collapse into one pending trigger. That trigger starts exactly one further burst after the current burst ends.
- R9: A one-cycle clrTrig pulse discards the pending trigger. It also makes the running burst end at the next grant, after which itemReq goes low.
- R10: srcWrapOut is high with the last item of a burst only when cfgBurstEn=1 and cfgSrcWrap=1. dstWrapOut behaves the same way with cfgDstWrap. With cfgBurstEn=0, neither wrap output ever rises.
- R11: Once raised, itemReq stays high until a grant occurs. itemAck has no effect while itemReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Raw hardware trigger line, asynchronous to clk |
| clrTrig | input | 1 | Software clear: drops the pending trigger and stops the burst |
| cfgTrigEn | input | 1 | Hardware trigger enable |
| cfgTrigLevel | input | 1 | 0 = edge sensitive, 1 = level sensitive |
| cfgTrigPol | input | 1 | 0 = falling edge or low level, 1 = rising edge or high level |
| cfgBurstEn | input | 1 | 0 = one item per trigger, 1 = burst mode |
| cfgBurstPow | input | POW_W | Burst size exponent P; the burst length is 2^P |
| cfgSrcWrap | input | 1 | Source address wraps at the end of a burst |
| cfgDstWrap | input | 1 | Destination address wraps at the end of a burst |
| itemAck | input | 1 | Engine accepts the requested item |
| itemReq | output | 1 | An item is requested |
| burstLast | output | 1 | The requested item is the last one of the burst |
| srcWrapOut | output | 1 | Reload the source address after this item |
| dstWrapOut | output | 1 | Reload the destination address after this item |

## Verification
The bench aims at the exponent limits: P=0 must grant a single item and an out-of-range P must stop at 1024. A counter that is one bit short or clamped wrongly would grant too few items or run on forever. It fires several edges into one running burst. A design without a collapsing pending flag would lose all of them or replay each one, and either shows up as a wrong grant total. It pulses clear while a trigger is pending and the engine is stalled, then checks that exactly one item follows and that the pending burst never starts. The bench also checks the exact sync latency and that the trailing edge of a pulse does not retrigger, which would expose a missing stage or an inverted polarity.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;

  // Strobes from the control FSM to the burst counter in the datapath.
  typedef struct packed {
    logic load;
    logic dec;
  } cnt_strobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } burst_state_e;

endpackage

// File: rtl/trig_qual_dp.sv
module trig_qual_dp
  import trig_qual_pkg::*;
#(
  parameter int MAX_POW     = 10,
  parameter int POW_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             cfgTrigEn,
  input  logic             cfgTrigLevel,
  input  logic             cfgTrigPol,
  input  logic             cfgBurstEn,
  input  logic [POW_W-1:0] cfgBurstPow,
  input  cnt_strobe_t      stb,
  output logic             edgeHit,
  output logic             levelOn,
  output logic             cntLast
);

  localparam int CNT_W = (MAX_POW > 0) ? MAX_POW : 1;

  // Synchronizer chain.
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= trigIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  logic trigSync;
  logic trigPrevQ;
  assign trigSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrevQ <= 1'b0;
    else       trigPrevQ <= trigSync;
  end

  // Polarity folds the line into an "active" sense.
  logic activeNow;
  logic activePrev;
  assign activeNow  = cfgTrigPol ? trigSync  : ~trigSync;
  assign activePrev = cfgTrigPol ? trigPrevQ : ~trigPrevQ;

  assign edgeHit = cfgTrigEn & ~cfgTrigLevel & activeNow & ~activePrev;
  assign levelOn = cfgTrigEn &  cfgTrigLevel & activeNow;

  // Burst counter holds the number of items still to go, minus one.
  logic [POW_W-1:0] powEff;
  logic [CNT_W:0]   lenFull;
  logic [CNT_W-1:0] lenM1;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    if (int'(cfgBurstPow) > MAX_POW) powEff = POW_W'(MAX_POW);
    else                             powEff = cfgBurstPow;
    lenFull = ({{CNT_W{1'b0}}, 1'b1} << powEff) - 1'b1;
    lenM1   = cfgBurstEn ? lenFull[CNT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntQ <= '0;
    else if (stb.load) cntQ <= lenM1;
    else if (stb.dec)  cntQ <= cntQ - 1'b1;
  end

  assign cntLast = (cntQ == '0);

  // R3: an active edge is a one-cycle event unless the polarity was changed.
  a_r3_edge_single: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> (!edgeHit || !$stable(cfgTrigPol)));

  // R6: the counter never loads and decrements in the same cycle.
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load && stb.dec));

endmodule

// File: rtl/trig_qual_ctrl.sv
module trig_qual_ctrl
  import trig_qual_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        edgeHit,
  input  logic        levelOn,
  input  logic        cntLast,
  input  logic        clrTrig,
  input  logic        itemAck,
  output cnt_strobe_t stb,
  output logic        itemReq,
  output logic        stopping
);

  burst_state_e stateQ, stateD;
  logic pendQ, pendD;
  logic stopQ, stopD;
  logic startReq;

  assign startReq = ~clrTrig & (edgeHit | levelOn | pendQ);

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    pendD  = pendQ;
    stopD  = stopQ;
    unique case (stateQ)
      ST_IDLE: begin
        stopD = 1'b0;
        if (clrTrig) pendD = 1'b0;
        if (startReq) begin
          stb.load = 1'b1;
          stateD   = ST_BURST;
          pendD    = 1'b0;
        end
      end
      ST_BURST: begin
        if (edgeHit) pendD = 1'b1;
        if (clrTrig) begin
          pendD = 1'b0;
          stopD = 1'b1;
        end
        if (itemAck) begin
          if (cntLast || stopQ || clrTrig) begin
            stateD = ST_IDLE;
            stopD  = 1'b0;
          end else begin
            stb.dec = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pendQ  <= 1'b0;
      stopQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
      stopQ  <= stopD;
    end
  end

  assign itemReq  = (stateQ == ST_BURST);
  assign stopping = stopQ;

  // R11: a request is held until the engine accepts it.
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (itemReq && !itemAck) |=> itemReq);

  // R9: a clear coinciding with a grant ends the burst at once.
  a_r9_clr_stop: assert property (@(posedge clk) disable iff (!rstN)
    (clrTrig && itemReq && itemAck) |=> !itemReq);

  // R4: a request only starts from a detected trigger or a pending one.
  a_r4_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(itemReq) |-> $past(edgeHit || levelOn || pendQ));

  // R6: the counter is never decremented past its last item.
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec |-> !cntLast);

endmodule

// File: rtl/trig_burst_qual.sv
module trig_burst_qual
  import trig_qual_pkg::*;
#(
  parameter int MAX_POW     = 10,
  parameter int POW_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             clrTrig,
  input  logic             cfgTrigEn,
  input  logic             cfgTrigLevel,
  input  logic             cfgTrigPol,
  input  logic             cfgBurstEn,
  input  logic [POW_W-1:0] cfgBurstPow,
  input  logic             cfgSrcWrap,
  input  logic             cfgDstWrap,
  input  logic             itemAck,
  output logic             itemReq,
  output logic             burstLast,
  output logic             srcWrapOut,
  output logic             dstWrapOut
);

  cnt_strobe_t stb;
  logic edgeHit;
  logic levelOn;
  logic cntLast;
  logic stopping;

  trig_qual_dp #(
    .MAX_POW    (MAX_POW),
    .POW_W      (POW_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .cfgTrigEn   (cfgTrigEn),
    .cfgTrigLevel(cfgTrigLevel),
    .cfgTrigPol  (cfgTrigPol),
    .cfgBurstEn  (cfgBurstEn),
    .cfgBurstPow (cfgBurstPow),
    .stb         (stb),
    .edgeHit     (edgeHit),
    .levelOn     (levelOn),
    .cntLast     (cntLast)
  );

  trig_qual_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .edgeHit (edgeHit),
    .levelOn (levelOn),
    .cntLast (cntLast),
    .clrTrig (clrTrig),
    .itemAck (itemAck),
    .stb     (stb),
    .itemReq (itemReq),
    .stopping(stopping)
  );

  logic wrapSlot;
  assign burstLast  = itemReq & cntLast;
  assign wrapSlot   = burstLast & cfgBurstEn & ~stopping;
  assign srcWrapOut = wrapSlot & cfgSrcWrap;
  assign dstWrapOut = wrapSlot & cfgDstWrap;

  // R10: a grant of the last item closes the burst.
  a_r10_wrap_ends_burst: assert property (@(posedge clk) disable iff (!rstN)
    (burstLast && itemAck) |=> !itemReq || $past(stopping) == 1'b0);

  // R10: no wrap is signalled without burst mode.
  a_r10_no_wrap_single: assert property (@(posedge clk) disable iff (!rstN)
    !cfgBurstEn |-> !(srcWrapOut || dstWrapOut));

endmodule

// File: tb/trig_burst_qual_bench.sv
module trig_burst_qual_bench;

  localparam int POW_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic clrTrig = 1'b0;
  logic cfgTrigEn = 1'b0;
  logic cfgTrigLevel = 1'b0;
  logic cfgTrigPol = 1'b1;
  logic cfgBurstEn = 1'b0;
  logic [POW_W-1:0] cfgBurstPow = '0;
  logic cfgSrcWrap = 1'b0;
  logic cfgDstWrap = 1'b0;
  logic itemAck = 1'b0;
  logic itemReq, burstLast, srcWrapOut, dstWrapOut;

  trig_burst_qual u_trig_burst_qual (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .clrTrig(clrTrig),
    .cfgTrigEn(cfgTrigEn), .cfgTrigLevel(cfgTrigLevel), .cfgTrigPol(cfgTrigPol),
    .cfgBurstEn(cfgBurstEn), .cfgBurstPow(cfgBurstPow),
    .cfgSrcWrap(cfgSrcWrap), .cfgDstWrap(cfgDstWrap), .itemAck(itemAck),
    .itemReq(itemReq), .burstLast(burstLast),
    .srcWrapOut(srcWrapOut), .dstWrapOut(dstWrapOut)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int grants = 0;
  int lastCnt = 0;
  int srcCnt = 0;
  int dstCnt = 0;
  int reqSeen = 0;
  bit ackRandom = 1'b0;
  bit ackLevel = 1'b1;
  bit done = 1'b0;
  int unsigned seedInit;

  initial seedInit = $urandom(32'd20240611);

  // Engine model: acknowledge pattern changes at the falling edge.
  always @(negedge clk) begin
    if (ackRandom) itemAck <= (($urandom % 3) != 0);
    else           itemAck <= ackLevel;
  end

  // Grant monitor, sampled mid low phase.
  always @(negedge clk) begin
    #3;
    if (itemReq) reqSeen++;
    if (itemReq && itemAck) begin
      grants++;
      if (burstLast)  lastCnt++;
      if (srcWrapOut) srcCnt++;
      if (dstWrapOut) dstCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clearCounts();
    grants = 0; lastCnt = 0; srcCnt = 0; dstCnt = 0; reqSeen = 0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    for (int i = 0; i < 20000 && quiet < 10; i++) begin
      step(1);
      if (itemReq) quiet = 0;
      else         quiet++;
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    trigIn = ~trigIn;
    step(hi);
    trigIn = ~trigIn;
    step(lo);
  endtask

  function automatic int burstLen(input bit burst, input int pw);
    if (!burst) return 1;
    return 1 << ((pw > 10) ? 10 : pw);
  endfunction

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finishUp();
    end
  end

  initial begin
    step(3);
    // R1: reset state
    check(!itemReq && !burstLast && !srcWrapOut && !dstWrapOut, "R1 reset outputs",
          {itemReq, burstLast, srcWrapOut, dstWrapOut}, 0);
    rstN = 1'b1;
    step(5);
    check(reqSeen == 0, "R1 nothing pending after reset", reqSeen, 0);

    // R2: trigger disabled
    clearCounts();
    for (int i = 0; i < 6; i++) pulse(3, 3);
    step(10);
    check(reqSeen == 0, "R2 disabled trigger", reqSeen, 0);

    // R4: latency through the synchronizer, rising edge, single item
    cfgTrigEn = 1'b1;
    ackLevel = 1'b1;
    step(5);
    clearCounts();
    trigIn = 1'b1;
    step(2);
    check(itemReq == 1'b0, "R4 no request before third edge", itemReq, 0);
    step(1);
    check(itemReq == 1'b1, "R4 request after third edge", itemReq, 1);
    step(4);
    check(grants == 1, "R3 rising edge grants one", grants, 1);
    // R3: falling edge ignored with polarity 1
    clearCounts();
    trigIn = 1'b0;
    step(10);
    check(grants == 0, "R3 falling edge ignored", grants, 0);
    // R3: polarity 0 uses falling edge
    trigIn = 1'b1;
    step(6);
    cfgTrigPol = 1'b0;
    step(3);
    clearCounts();
    trigIn = 1'b0;
    step(8);
    check(grants == 1, "R3 falling edge with polarity 0", grants, 1);
    clearCounts();
    trigIn = 1'b1;
    step(8);
    check(grants == 0, "R3 rising edge ignored with polarity 0", grants, 0);
    trigIn = 1'b0;
    step(6);
    cfgTrigPol = 1'b1;
    step(3);

    // R5: random single-item triggers with random acks
    ackRandom = 1'b1;
    clearCounts();
    for (int i = 0; i < 20; i++) begin
      pulse(1 + ($urandom % 4), 1 + ($urandom % 4));
      waitIdle();
    end
    check(grants == 20, "R5 one item per trigger", grants, 20);
    cfgSrcWrap = 1'b1;
    cfgDstWrap = 1'b1;
    clearCounts();
    pulse(3, 3);
    waitIdle();
    check(srcCnt + dstCnt == 0, "R10 no wrap without burst", srcCnt + dstCnt, 0);

    // R6 and R10: random bursts
    cfgBurstEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      int pw = $urandom % 10;
      bit sw = $urandom % 2;
      bit dw = $urandom % 2;
      cfgBurstPow = POW_W'(pw);
      cfgSrcWrap = sw;
      cfgDstWrap = dw;
      clearCounts();
      pulse(3, 3);
      waitIdle();
      check(grants == burstLen(1'b1, pw), "R6 burst length", grants, burstLen(1'b1, pw));
      check(lastCnt == 1, "R6 one last item", lastCnt, 1);
      check(srcCnt == int'(sw) && dstCnt == int'(dw), "R10 wrap flags",
            srcCnt * 2 + dstCnt, int'(sw) * 2 + int'(dw));
    end
    // R6: exponent out of range clamps to 1024
    cfgBurstPow = 4'd12;
    clearCounts();
    pulse(3, 3);
    waitIdle();
    check(grants == 1024, "R6 clamped burst", grants, 1024);

    // R8: edges during a stalled burst collapse into one
    ackRandom = 1'b0;
    ackLevel = 1'b0;
    cfgBurstPow = 4'd4;
    clearCounts();
    pulse(3, 3);
    for (int i = 0; i < 3; i++) pulse(3, 3);
    check(itemReq == 1'b1 && grants == 0, "R11 request held without ack", grants, 0);
    ackLevel = 1'b1;
    waitIdle();
    check(grants == 32, "R8 pending serves one burst", grants, 32);

    // R9: clear drops pending and cuts the burst
    ackLevel = 1'b0;
    cfgBurstPow = 4'd5;
    clearCounts();
    pulse(3, 3);
    pulse(3, 3);
    clrTrig = 1'b1;
    step(1);
    clrTrig = 1'b0;
    step(3);
    check(itemReq == 1'b1, "R9 request held until item done", itemReq, 1);
    ackLevel = 1'b1;
    waitIdle();
    check(grants == 1, "R9 clear ends burst", grants, 1);
    step(20);
    check(grants == 1, "R9 pending discarded", grants, 1);

    // R7: level mode repeats bursts while active
    cfgTrigLevel = 1'b1;
    cfgBurstPow = 4'd2;
    clearCounts();
    trigIn = 1'b1;
    step(40);
    trigIn = 1'b0;
    waitIdle();
    check(grants >= 8 && (grants % 4) == 0, "R7 repeated whole bursts", grants, 8);
    clearCounts();
    step(20);
    check(grants == 0, "R7 stops when level inactive", grants, 0);

    done = 1'b1;
    finishUp();
  end

endmodule